// File: doc/BRIEF.md
# Memory-to-Stream DMA Channel

This block is one DMA channel that moves a block of 32-bit words from system memory onto a valid/ready output stream. Software programs it through three registers: a source address, a word count and a control register. Setting control bit 0 launches the transfer. The channel then fetches one word at a time through a read-master port, tagging each request with a fixed master identifier, and presents the word on the stream. The stream carries a last flag on the final word.

During the run, the address register is a live pointer that steps by four after every fetched word. A trace port reports each step of the lifecycle: a configuration event when address or count is written, a start event, a beat event for every word the sink accepts, and a done pulse. Control bit 0 clears itself when the block finishes. A completion counter then advances. If the sink holds off, the channel freezes in place and keeps its state.

Top module: `dma_stream_channel`

## Requirements
- R1: A read request returns data with `regRdValid` one cycle later. Offset 0x0 returns the live address pointer, 0x4 returns the count as written, and 0x8 returns control bit 0 in bit 0. Any other offset returns 0.
- R2: While idle, a write to offset 0x0 or 0x4 stores the value and raises `evValid` with `evKind`=1 (configuration) in the same cycle. It does not start a transfer, and `busy` stays 0.
- R3: While idle, a write to offset 0x8 with bit 0 set raises `evKind`=2 (start) in the same cycle. It makes `busy` high from the next cycle, and control bit 0 then reads 1.
- R4: Each word is fetched with exactly one single-cycle `memRdEn` pulse at the current pointer, with `memMasterId`=4. After the word returns on `memRdValid`, the pointer advances by 4.
- R5: Exactly count words reach the stream, in ascending address order. While `strmValid` is high and `strmReady` is low, `strmValid`, `strmData` and `strmLast` hold. `strmLast` is high only on the final word.
- R6: Every cycle in which a word is accepted raises `evKind`=3 (beat). In that cycle `evAddr` is the word's source address and `evRemain` is the count still left after this word. Outside beats both are 0.
- R7: `evDone` pulses in the cycle the final word is accepted. From the next cycle, `busy` is 0, control bit 0 reads 0, and `doneCount` has grown by one.
- R8: While the sink holds `strmReady` low, `busy` stays high, and no beat event or done pulse occurs. The transfer completes once ready returns.
- R9: A start with count 0 raises the start event, then gives a done pulse in the next cycle. It produces no fetch and no stream word.
- R10: Register writes made while `busy` is high have no effect.
- R11: After reset, `busy`, `doneCount`, `strmValid`, `memRdEn` and `evValid` are 0, and every register reads 0.
- R12: Each word occupies at least two cycles. After an accepted word that is not the last, `strmValid` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regOffset | input | 4 | Byte offset within the channel window |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data |
| regRdValid | output | 1 | Read data valid, one cycle after request |
| memRdEn | output | 1 | Memory read request |
| memRdAddr | output | 32 | Memory read address |
| memMasterId | output | 8 | Requesting master identifier |
| memRdData | input | 32 | Memory read data |
| memRdValid | input | 1 | Memory read data valid |
| strmValid | output | 1 | Stream word valid |
| strmData | output | 32 | Stream word |
| strmLast | output | 1 | Final word of the block |
| strmReady | input | 1 | Sink ready |
| busy | output | 1 | Transfer in progress |
| doneCount | output | 32 | Completed transfers |
| evValid | output | 1 | Trace event valid |
| evKind | output | 2 | 1 configuration, 2 start, 3 beat |
| evAddr | output | 32 | Beat source address |
| evRemain | output | 32 | Words left after this beat |
| evDone | output | 1 | Transfer completion pulse |

## Verification
The reference model is exercised with several stimulus patterns, each separating different faults:

- **Always-ready sink, one-cycle memory:** shows the minimum two-cycle pace per word and the pointer stepping.
- **Sink held low from the start, three-cycle memory:** proves the channel freezes without a false done, and that writes landing during the freeze are dropped.
- **Alternating ready:** catches data or last-flag changes under partial backpressure.
- **Zero-length and one-word blocks:** separate the done-without-beat path from the last-flag-on-first-word path.
- **Readback of each offset, including an unmapped one:** distinguishes the live pointer from the stored count.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int DATA_W = 32;
  localparam int OFF_W = 4;
  localparam logic [OFF_W-1:0] OFF_ADDR = 4'h0;
  localparam logic [OFF_W-1:0] OFF_COUNT = 4'h4;
  localparam logic [OFF_W-1:0] OFF_CTRL = 4'h8;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_SEND, ST_FINISH} chanState_t;
  typedef enum logic [1:0] {EV_NONE = 2'd0, EV_CFG = 2'd1, EV_START = 2'd2, EV_BEAT = 2'd3} evKind_t;

  typedef struct packed {
    logic wrAddr;
    logic wrCount;
    logic start;
    logic fetchDone;
    logic beatTaken;
    logic finish;
  } dpStrobe_t;
endpackage

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [OFF_W-1:0] regOffset,
  input  logic             regWrBit0,
  input  logic             memRdValid,
  input  logic             strmReady,
  input  logic             countZero,
  input  logic             lastBeat,
  output logic             busy,
  output logic             memRdEn,
  output logic             strmValid,
  output dpStrobe_t        strobe,
  output evKind_t          evKind,
  output logic             evDone
);
  chanState_t state, stateNext;
  logic reqOut;
  logic idle, cfgWr, startWr, accept;

  assign idle    = (state == ST_IDLE);
  assign cfgWr   = idle && regWrEn && (regOffset == OFF_ADDR || regOffset == OFF_COUNT);
  assign startWr = idle && regWrEn && (regOffset == OFF_CTRL) && regWrBit0;
  assign accept  = (state == ST_SEND) && strmReady;

  always_comb begin
    strobe           = '0;
    strobe.wrAddr    = idle && regWrEn && (regOffset == OFF_ADDR);
    strobe.wrCount   = idle && regWrEn && (regOffset == OFF_COUNT);
    strobe.start     = startWr;
    strobe.fetchDone = (state == ST_FETCH) && memRdValid;
    strobe.beatTaken = accept;
    strobe.finish    = (accept && lastBeat) || (state == ST_FINISH);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (startWr) stateNext = countZero ? ST_FINISH : ST_FETCH;
      ST_FETCH:  if (memRdValid) stateNext = ST_SEND;
      ST_SEND:   if (accept) stateNext = lastBeat ? ST_IDLE : ST_FETCH;
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      reqOut <= 1'b0;
    end else begin
      state <= stateNext;
      if (memRdValid) reqOut <= 1'b0;
      else if (memRdEn) reqOut <= 1'b1;
    end
  end

  assign busy      = !idle;
  assign memRdEn   = (state == ST_FETCH) && !reqOut;
  assign strmValid = (state == ST_SEND);
  assign evDone    = strobe.finish;

  always_comb begin
    if (cfgWr) evKind = EV_CFG;
    else if (startWr) evKind = EV_START;
    else if (accept) evKind = EV_BEAT;
    else evKind = EV_NONE;
  end

  // R4
  one_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strmValid && !strmReady) |=> (busy && strmValid));
  // R2
  cfg_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evKind == EV_CFG) |=> !busy);
  // R12
  two_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !lastBeat) |=> !strmValid);
endmodule

// File: rtl/dma_chan_dp.sv
module dma_chan_dp
  import dma_chan_pkg::*;
#(
  parameter int ADDR_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              busy,
  input  logic              strmValid,
  input  logic              strmReady,
  input  logic              regRdEn,
  input  logic [OFF_W-1:0]  regOffset,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] regRdData,
  output logic              regRdValid,
  output logic [DATA_W-1:0] memRdAddr,
  output logic [DATA_W-1:0] strmData,
  output logic              strmLast,
  output logic              countZero,
  output logic              lastBeat,
  output logic [DATA_W-1:0] doneCount,
  output logic [DATA_W-1:0] evAddr,
  output logic [DATA_W-1:0] evRemain
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(ADDR_STEP);

  logic [DATA_W-1:0] addrPtr, countReg, remain, wordReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrPtr    <= '0;
      countReg   <= '0;
      remain     <= '0;
      wordReg    <= '0;
      doneCount  <= '0;
      regRdData  <= '0;
      regRdValid <= 1'b0;
    end else begin
      if (strobe.wrAddr) addrPtr <= regWrData;
      if (strobe.wrCount) countReg <= regWrData;
      if (strobe.start) remain <= countReg;
      if (strobe.fetchDone) begin
        wordReg <= memRdData;
        addrPtr <= addrPtr + STEP;
      end
      if (strobe.beatTaken) remain <= remain - 1'b1;
      if (strobe.finish) doneCount <= doneCount + 1'b1;
      regRdValid <= regRdEn;
      if (regRdEn) begin
        unique case (regOffset)
          OFF_ADDR:  regRdData <= addrPtr;
          OFF_COUNT: regRdData <= countReg;
          OFF_CTRL:  regRdData <= {{(DATA_W-1){1'b0}}, busy};
          default:   regRdData <= '0;
        endcase
      end
    end
  end

  assign memRdAddr = addrPtr;
  assign strmData  = wordReg;
  assign lastBeat  = (remain == 1);
  assign strmLast  = lastBeat;
  assign countZero = (countReg == '0);
  assign evAddr    = strobe.beatTaken ? (addrPtr - STEP) : '0;
  assign evRemain  = strobe.beatTaken ? (remain - 1'b1) : '0;

  // R5
  data_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strmValid && !strmReady) |=> ($stable(strmData) && $stable(strmLast)));
  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fetchDone |=> (memRdAddr == $past(memRdAddr) + STEP));
  // R7
  done_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> (doneCount == $past(doneCount) + 1'b1));
endmodule

// File: rtl/dma_stream_channel.sv
module dma_stream_channel
  import dma_chan_pkg::*;
#(
  parameter int          ADDR_STEP = 4,
  parameter logic [7:0]  MASTER_ID = 8'd4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [3:0]  regOffset,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        regRdValid,
  output logic        memRdEn,
  output logic [31:0] memRdAddr,
  output logic [7:0]  memMasterId,
  input  logic [31:0] memRdData,
  input  logic        memRdValid,
  output logic        strmValid,
  output logic [31:0] strmData,
  output logic        strmLast,
  input  logic        strmReady,
  output logic        busy,
  output logic [31:0] doneCount,
  output logic        evValid,
  output logic [1:0]  evKind,
  output logic [31:0] evAddr,
  output logic [31:0] evRemain,
  output logic        evDone
);
  dpStrobe_t strobe;
  evKind_t   kind;
  logic      countZero, lastBeat;

  dma_chan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regOffset(regOffset),
    .regWrBit0(regWrData[0]), .memRdValid(memRdValid), .strmReady(strmReady),
    .countZero(countZero), .lastBeat(lastBeat), .busy(busy), .memRdEn(memRdEn),
    .strmValid(strmValid), .strobe(strobe), .evKind(kind), .evDone(evDone)
  );

  dma_chan_dp #(.ADDR_STEP(ADDR_STEP)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy), .strmValid(strmValid),
    .strmReady(strmReady), .regRdEn(regRdEn), .regOffset(regOffset),
    .regWrData(regWrData), .memRdData(memRdData), .regRdData(regRdData),
    .regRdValid(regRdValid), .memRdAddr(memRdAddr), .strmData(strmData),
    .strmLast(strmLast), .countZero(countZero), .lastBeat(lastBeat),
    .doneCount(doneCount), .evAddr(evAddr), .evRemain(evRemain)
  );

  assign evKind      = kind;
  assign evValid     = (kind != EV_NONE);
  assign memMasterId = MASTER_ID;

  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (kind == EV_START && countZero) |=> (evDone && !strmValid && !memRdEn));
  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (kind == EV_START) |=> busy);
endmodule

// File: tb/dma_stream_channel_test.sv
`timescale 1ns/1ps
module dma_stream_channel_test;
  logic clk = 1'b0, rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic regWrEn = 0, regRdEn = 0, memRdValid = 0, strmReady = 1;
  logic [3:0] regOffset = 0;
  logic [31:0] regWrData = 0, memRdData = 0;
  logic [31:0] regRdData, memRdAddr, strmData, doneCount, evAddr, evRemain;
  logic regRdValid, memRdEn, strmValid, strmLast, busy, evValid, evDone;
  logic [7:0] memMasterId;
  logic [1:0] evKind;

  dma_stream_channel uut (.*);

  int checks = 0, errors = 0;
  // reference model state
  int mState = 0; bit mReq = 0;
  logic [31:0] mAddr = 0, mCount = 0, mRemain = 0, mWord = 0, mDone = 0, mRd = 0;
  bit mRdV = 0;
  // environment
  int memLat = 1, pend = 0; logic [31:0] pendData = 0;
  bit seenEn = 0; logic [31:0] seenAddr = 0;
  logic [31:0] obsRd = 0;
  int beatsSeen = 0, reqSeen = 0;
  logic [31:0] gotWords[$];

  function automatic logic [31:0] memWord(logic [31:0] a);
    return 32'hA000_0000 + (a >> 2) * 32'h0101_0011;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    bit expEn, expV, acc, expDone; logic [1:0] expKind; logic [31:0] expEA, expER;
    @(negedge clk);
    if (rstN) begin
      expEn = (mState == 1) && !mReq;
      expV = (mState == 2);
      acc = expV && strmReady;
      expDone = (acc && mRemain == 1) || mState == 3;
      expKind = 0; expEA = 0; expER = 0;
      if (mState == 0 && regWrEn && (regOffset == 0 || regOffset == 4)) expKind = 1;
      else if (mState == 0 && regWrEn && regOffset == 8 && regWrData[0]) expKind = 2;
      else if (acc) begin expKind = 3; expEA = mAddr - 4; expER = mRemain - 1; end
      chk(busy === (mState != 0), "R3/R7 busy", busy, mState != 0);
      chk(memRdEn === expEn, "R4 memRdEn", memRdEn, expEn);
      if (expEn) chk(memRdAddr === mAddr && memMasterId === 8'd4, "R4 fetch addr/id", memRdAddr, mAddr);
      chk(strmValid === expV, "R12 strmValid", strmValid, expV);
      if (expV) chk(strmData === mWord && strmLast === (mRemain == 1), "R5 strm word/last", strmData, mWord);
      chk(evValid === (expKind != 0) && evKind === expKind, "R2/R3/R6 evKind", evKind, expKind);
      chk(evAddr === expEA && evRemain === expER, "R6 beat addr/remain", evAddr, expEA);
      chk(evDone === expDone, "R7 evDone", evDone, expDone);
      chk(doneCount === mDone, "R7 doneCount", doneCount, mDone);
      chk(regRdValid === mRdV, "R1 rdValid", regRdValid, mRdV);
      if (mRdV) chk(regRdData === mRd, "R1 rdData", regRdData, mRd);
      obsRd = regRdData;
      if (evValid && evKind == 2'd3) beatsSeen++;
      if (memRdEn) reqSeen++;
      if (strmValid && strmReady) gotWords.push_back(strmData);
    end
    seenEn = memRdEn; seenAddr = memRdAddr;
    @(posedge clk);
    if (rstN) begin
      mRdV = regRdEn;
      if (regRdEn)
        mRd = (regOffset == 0) ? mAddr : (regOffset == 4) ? mCount :
              (regOffset == 8) ? 32'(mState != 0) : 32'd0;
      case (mState)
        0: if (regWrEn) begin
             if (regOffset == 0) mAddr = regWrData;
             if (regOffset == 4) mCount = regWrData;
             if (regOffset == 8 && regWrData[0]) begin
               mRemain = mCount; mState = (mCount == 0) ? 3 : 1;
             end
           end
        1: begin
             if (memRdValid) begin
               mWord = memRdData; mAddr += 4; mReq = 0; mState = 2;
             end else if (!mReq) mReq = 1;
           end
        2: if (strmReady) begin
             if (mRemain == 1) begin mState = 0; mDone++; end else mState = 1;
             mRemain--;
           end
        default: begin mState = 0; mDone++; end
      endcase
    end
    if (pend > 0) pend--;
    if (seenEn) begin pend = memLat; pendData = memWord(seenAddr); end
    #1;
    memRdValid = (pend == 1);
    memRdData = (pend == 1) ? pendData : 32'd0;
  endtask

  task automatic wr(logic [3:0] off, logic [31:0] d);
    regWrEn = 1; regOffset = off; regWrData = d; step();
    regWrEn = 0; regWrData = 0;
  endtask

  task automatic rd(logic [3:0] off, output logic [31:0] v);
    regRdEn = 1; regOffset = off; step();
    regRdEn = 0; step(); v = obsRd;
  endtask

  task automatic runIdle(int pattern);
    for (int i = 0; i < 400 && mState != 0; i++) begin
      strmReady = (pattern == 0) ? 1'b1 : 1'(i % 2);
      step();
    end
    strmReady = 1; step();
  endtask

  task automatic checkWords(logic [31:0] base, int n, string tag);
    chk(gotWords.size() == n, tag, gotWords.size(), n);
    for (int i = 0; i < n && i < gotWords.size(); i++)
      chk(gotWords[i] === memWord(base + 4 * i), tag, gotWords[i], memWord(base + 4 * i));
    gotWords.delete();
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R11 reset state
    step();
    chk(busy === 0 && doneCount === 0 && strmValid === 0 && evValid === 0, "R11 reset outputs", busy, 0);
    rd(4'h0, v); chk(v === 0, "R11 addr after reset", v, 0);
    // R2 configuration only
    wr(4'h0, 32'h100); wr(4'h4, 4);
    repeat (3) step();
    chk(busy === 0 && reqSeen == 0, "R2 no start on cfg", busy, 0);
    // R3 start, always ready, latency 1
    wr(4'h8, 1);
    rd(4'h8, v); chk(v === 1, "R3 ctrl bit set", v, 1);
    runIdle(0);
    checkWords(32'h100, 4, "R5 words in order");
    rd(4'h8, v); chk(v === 0, "R7 ctrl bit cleared", v, 0);
    chk(doneCount === 1, "R7 done count 1", doneCount, 1);
    rd(4'h0, v); chk(v === 32'h110, "R1 live pointer", v, 32'h110);
    rd(4'h4, v); chk(v === 4, "R1 count kept", v, 4);
    rd(4'hC, v); chk(v === 0, "R1 unmapped offset", v, 0);
    // R8 stall from start, latency 3, R10 writes while busy
    memLat = 3; beatsSeen = 0;
    wr(4'h0, 32'h40); wr(4'h4, 3);
    strmReady = 0; wr(4'h8, 1);
    wr(4'h0, 32'h999); wr(4'h4, 32'h7);
    repeat (15) step();
    chk(busy === 1 && doneCount === 1 && beatsSeen == 0, "R8 frozen under stall", doneCount, 1);
    strmReady = 1;
    runIdle(0);
    checkWords(32'h40, 3, "R8 resumed words");
    rd(4'h0, v); chk(v === 32'h4C, "R10 write while busy dropped", v, 32'h4C);
    rd(4'h4, v); chk(v === 3, "R10 count unchanged", v, 3);
    // alternating ready, latency 2
    memLat = 2;
    wr(4'h0, 32'h200); wr(4'h4, 5); wr(4'h8, 1);
    runIdle(1);
    checkWords(32'h200, 5, "R5 alternating ready");
    // R9 zero count
    reqSeen = 0; beatsSeen = 0;
    wr(4'h4, 0); wr(4'h8, 1);
    step(); step();
    chk(doneCount === 4 && reqSeen == 0 && beatsSeen == 0, "R9 zero-length done", doneCount, 4);
    // single word
    memLat = 1;
    wr(4'h0, 32'h80); wr(4'h4, 1); wr(4'h8, 1);
    runIdle(1);
    checkWords(32'h80, 1, "R5 single word");
    chk(doneCount === 5, "R7 final count", doneCount, 5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule